// File: doc/BRIEF.md
# Two-Stage Baud Rate Divider

This block turns a core clock into the two timing strobes a serial port needs. The first is a bit-sample enable. The second is a baud tick that marks the end of each bit period. A select input first picks the clock source. The source is either the core clock itself, which gives an enable on every cycle, or the core clock divided by 8. A programmable generator divisor then thins that source enable into the sample enable. A second, 8-bit bit divisor counts sample enables and divides them by its value plus one. The resulting baud rate is source / ((bit divisor + 1) × generator divisor).

Both divisors are written through a one-cycle write strobe with a one-bit register select. A write goes into a pending copy. Each stage adopts its pending value only at its own terminal count, so a period that is already running always completes at its old length. A write of less than 4 to the bit divisor is dropped, and the previous value stays in force.

The generator stage is a three-state machine. GS_DIVIDE counts source enables up to the divisor. GS_PASS forwards every source enable (divisor 1). GS_STOP suppresses the sample enable (divisor 0). All transitions happen only on a terminal event. In GS_STOP and GS_PASS a terminal event is any source enable; in GS_DIVIDE it is the enable on which the count reaches the divisor. On a terminal event the machine takes the transition named after the pending divisor: RELOAD_STOP when it is 0, RELOAD_PASS when it is 1, and RELOAD_DIVIDE when it is 2 or more. Reset enters GS_DIVIDE with a generator divisor of 651 and a bit divisor of 15.

Top module: `baud_divider`

## Requirements
- R1: After reset the generator divisor is 651 and the bit divisor is 15. With clk_sel low, the first sample_en comes on the 651st cycle after reset is released, and the first baud_tick comes on the 16th sample_en. Both outputs are low in the first cycle after release.
- R2: With clk_sel high, the source enable is active once every 8 core cycles. With clk_sel low, it is active on every cycle.
- R3: A generator divisor N of 2 or more gives exactly one sample_en per N source enables, and sample_en is never active without a source enable.
- R4: A generator divisor of 1 makes sample_en follow the source enable on every cycle.
- R5: A generator divisor of 0 keeps sample_en and baud_tick low.
- R6: baud_tick is active on exactly one sample_en out of every (bit divisor + 1), always in the same cycle as that sample_en. This holds across the full legal range 4 to 255.
- R7: A bit-divisor write takes wr_data[7:0] and ignores the upper bits. When wr_data[7:0] is less than 4 the write is dropped and the previous divisor is kept.
- R8: A new divisor takes effect only at the next terminal count of its own stage, either the next sample_en or the next baud_tick. The period in progress finishes at its old length.
- R9: Write address encoding: wr_sel = 0 writes the 16-bit generator divisor from wr_data, and wr_sel = 1 writes the bit divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 0: core clock feeds the chain; 1: core clock divided by 8 |
| wr_en | input | 1 | One-cycle divisor write strobe |
| wr_sel | input | 1 | 0: generator divisor, 1: bit divisor |
| wr_data | input | 16 | Write value |
| sample_en | output | 1 | Bit-sample enable strobe |
| baud_tick | output | 1 | One-cycle pulse at the end of each bit period |

## Verification
Two events can fall in the same cycle: a divisor write and the terminal count of the stage it targets. In that cycle the stage must reload from the value that was pending before the write, and the new value waits for the following terminal count. The bench provokes this by measuring gaps right after a strobe and by writing a rapid stream of generator values at varying spacings, some of which land on terminal cycles. A behavioural cycle model, compared on every clock, then judges which value each period used. A baud tick always falls on a sample enable as well, so the bench checks that pairing on every cycle.

// File: rtl/baud_pkg.sv
package baud_pkg;

    // Generator stage operating states
    typedef enum logic [1:0] {
        GS_STOP   = 2'd0,   // divisor 0: sample enable held low
        GS_PASS   = 2'd1,   // divisor 1: source enable forwarded
        GS_DIVIDE = 2'd2    // divisor >= 2: count source enables
    } gen_state_e;

    // Register select encoding on the write port
    typedef enum logic {
        SEL_GEN = 1'b0,
        SEL_BIT = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int PRE_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sel,
    output logic src_en
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    generate
        if (PRE_DIV > 1) begin : g_div
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
            logic [PRE_W-1:0] pre_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_cnt <= '0;
                end else if (pre_cnt == PRE_LAST) begin
                    pre_cnt <= '0;
                end else begin
                    pre_cnt <= pre_cnt + 1'b1;
                end
            end

            assign src_en = clk_sel ? (pre_cnt == PRE_LAST) : 1'b1;
        end else begin : g_nodiv
            assign src_en = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_pkg::*;
#(
    parameter int GEN_W   = 16,
    parameter int BIT_W   = 8,
    parameter int BIT_MIN = 4,
    parameter int GEN_RST = 651,
    parameter int BIT_RST = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [GEN_W-1:0] wr_data,
    output logic [GEN_W-1:0] gen_pend,
    output logic [BIT_W-1:0] bit_pend
);
    localparam logic [BIT_W-1:0] BIT_FLOOR = BIT_W'(BIT_MIN);

    logic [BIT_W-1:0] bit_wr;
    logic             bit_ok;

    assign bit_wr = wr_data[BIT_W-1:0];
    assign bit_ok = (bit_wr >= BIT_FLOOR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_pend <= GEN_W'(GEN_RST);
            bit_pend <= BIT_W'(BIT_RST);
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_GEN: gen_pend <= wr_data;
                SEL_BIT: if (bit_ok) bit_pend <= bit_wr;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/baud_gen_stage.sv
module baud_gen_stage
    import baud_pkg::*;
#(
    parameter int GEN_W   = 16,
    parameter int GEN_RST = 651
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_en,
    input  logic [GEN_W-1:0] gen_pend,
    output logic             sample_en,
    output gen_state_e       state_q
);
    function automatic gen_state_e classify(input logic [GEN_W-1:0] val);
        if (val == '0) begin
            return GS_STOP;
        end else if (val == GEN_W'(1)) begin
            return GS_PASS;
        end
        return GS_DIVIDE;
    endfunction

    localparam logic [GEN_W-1:0] GEN_INIT  = GEN_W'(GEN_RST);
    localparam gen_state_e       RST_STATE = classify(GEN_INIT);

    gen_state_e       state_d;
    logic [GEN_W-1:0] gen_act;
    logic [GEN_W-1:0] g_cnt;
    logic             term;

    // Terminal event of the current state
    always_comb begin
        unique case (state_q)
            GS_STOP, GS_PASS: term = src_en;
            GS_DIVIDE:        term = src_en && (g_cnt == gen_act);
            default:          term = 1'b0;
        endcase
    end

    // Transitions RELOAD_STOP / RELOAD_PASS / RELOAD_DIVIDE on terminal
    always_comb begin
        state_d = term ? classify(gen_pend) : state_q;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    // Active divisor and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_act <= GEN_INIT;
            g_cnt   <= GEN_W'(1);
        end else if (term) begin
            gen_act <= gen_pend;
            g_cnt   <= GEN_W'(1);
        end else if (src_en && (state_q == GS_DIVIDE)) begin
            g_cnt   <= g_cnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            GS_STOP:   sample_en = 1'b0;
            GS_PASS:   sample_en = src_en;
            GS_DIVIDE: sample_en = term;
            default:   sample_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/baud_bit_stage.sv
module baud_bit_stage #(
    parameter int BIT_W   = 8,
    parameter int BIT_RST = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [BIT_W-1:0] bit_pend,
    output logic             baud_tick,
    output logic [BIT_W-1:0] bit_act
);
    logic [BIT_W-1:0] b_cnt;
    logic             at_end;

    assign at_end    = (b_cnt == bit_act);
    assign baud_tick = sample_en && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_cnt   <= '0;
            bit_act <= BIT_W'(BIT_RST);
        end else if (baud_tick) begin
            b_cnt   <= '0;
            bit_act <= bit_pend;
        end else if (sample_en) begin
            b_cnt   <= b_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import baud_pkg::*;
#(
    parameter int PRE_DIV = 8,
    parameter int GEN_W   = 16,
    parameter int BIT_W   = 8,
    parameter int BIT_MIN = 4,
    parameter int GEN_RST = 651,
    parameter int BIT_RST = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_sel,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [GEN_W-1:0] wr_data,
    output logic             sample_en,
    output logic             baud_tick
);
    logic             src_en;
    logic [GEN_W-1:0] gen_pend;
    logic [BIT_W-1:0] bit_pend;
    logic [BIT_W-1:0] bit_act;
    gen_state_e       gen_state;

    baud_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .src_en  (src_en)
    );

    baud_cfg_regs #(
        .GEN_W(GEN_W), .BIT_W(BIT_W), .BIT_MIN(BIT_MIN),
        .GEN_RST(GEN_RST), .BIT_RST(BIT_RST)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .gen_pend (gen_pend),
        .bit_pend (bit_pend)
    );

    baud_gen_stage #(.GEN_W(GEN_W), .GEN_RST(GEN_RST)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_en    (src_en),
        .gen_pend  (gen_pend),
        .sample_en (sample_en),
        .state_q   (gen_state)
    );

    baud_bit_stage #(.BIT_W(BIT_W), .BIT_RST(BIT_RST)) u_bit (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .bit_pend  (bit_pend),
        .baud_tick (baud_tick),
        .bit_act   (bit_act)
    );
endmodule

// File: rtl/baud_divider_chk.sv
module baud_divider_chk
    import baud_pkg::*;
#(
    parameter int GEN_W   = 16,
    parameter int BIT_W   = 8,
    parameter int BIT_MIN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_sel,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [GEN_W-1:0] wr_data,
    input logic             src_en,
    input logic             sample_en,
    input logic             baud_tick,
    input gen_state_e       gen_state,
    input logic [BIT_W-1:0] bit_pend,
    input logic [BIT_W-1:0] bit_act
);
    AST_DIRECT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_sel |-> src_en); // R2
    AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel && src_en) |=> !(clk_sel && src_en)); // R2
    AST_SAMPLE_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> src_en); // R3
    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_state == GS_PASS) |-> (sample_en == src_en)); // R4
    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_state == GS_STOP) |-> (!sample_en && !baud_tick)); // R5
    AST_TICK_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> sample_en); // R6
    AST_LOW_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && (wr_data[BIT_W-1:0] < BIT_W'(BIT_MIN))) |=> $stable(bit_pend)); // R7
    AST_BIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_act >= BIT_W'(BIT_MIN)) && (bit_pend >= BIT_W'(BIT_MIN))); // R7
    AST_HOLD_UNTIL_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(bit_act)); // R8
    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en |=> $stable(gen_state)); // R8
endmodule

bind baud_divider baud_divider_chk #(
    .GEN_W(GEN_W), .BIT_W(BIT_W), .BIT_MIN(BIT_MIN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .src_en    (src_en),
    .sample_en (sample_en),
    .baud_tick (baud_tick),
    .gen_state (gen_state),
    .bit_pend  (bit_pend),
    .bit_act   (bit_act)
);

// File: tb/baud_divider_tb_top.sv
module baud_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        sample_en;
    logic        baud_tick;

    int checks = 0;
    int errors = 0;
    int cnt_s = 0;
    int cnt_b = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_pre, m_gcnt, m_gact, m_gpend, m_bcnt, m_bact, m_bpend;
    bit e_src, e_term, e_samp, e_tick;

    always #2 clk = ~clk;   // 250 MHz

    baud_divider dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel   (clk_sel),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .sample_en (sample_en),
        .baud_tick (baud_tick)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string samp_req();
        if (clk_sel) return "R2";
        if (m_gact == 0) return "R5";
        if (m_gact == 1) return "R4";
        return "R3";
    endfunction

    // cycle model, compared at every falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_gcnt = 1; m_gact = 651; m_gpend = 651;
            m_bcnt = 0; m_bact = 15; m_bpend = 15;
        end else if (!done) begin
            e_src  = clk_sel ? (m_pre == 7) : 1'b1;
            e_term = e_src && ((m_gact < 2) || (m_gcnt == m_gact));
            e_samp = e_term && (m_gact != 0);
            e_tick = e_samp && (m_bcnt == m_bact);
            chk(samp_req(), "sample_en model", int'(sample_en), int'(e_samp));
            chk("R6", "baud_tick model", int'(baud_tick), int'(e_tick));
            cnt_s += int'(sample_en);
            cnt_b += int'(baud_tick);
            m_pre = (m_pre + 1) % 8;
            if (e_term) begin
                m_gact = m_gpend; m_gcnt = 1;
            end else if (e_src) begin
                m_gcnt++;
            end
            if (e_tick) begin
                m_bcnt = 0; m_bact = m_bpend;
            end else if (e_samp) begin
                m_bcnt++;
            end
            if (wr_en) begin
                if (!wr_sel) m_gpend = int'(wr_data);
                else if (wr_data[7:0] >= 8'd4) m_bpend = int'(wr_data[7:0]);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic zero();
        cnt_s = 0; cnt_b = 0;
    endtask

    task automatic gap_to_next(input bit use_tick, output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!(use_tick ? baud_tick : sample_en));
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int g;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        zero();
        // R1: reset values, first-cycle outputs and first strobes
        @(negedge clk); #1;
        chk("R1", "sample_en after reset", int'(sample_en), 0);
        chk("R1", "baud_tick after reset", int'(baud_tick), 0);
        @(posedge clk); #1;
        run(10415);
        chk("R1", "sample count in 16*651 cycles", cnt_s, 16);
        chk("R1", "tick count in 16*651 cycles", cnt_b, 1);

        // R9 / R4: generator divisor 1 through select 0
        wr(1'b0, 16'd1);
        run(700); zero(); run(160);
        chk("R4", "samples with divisor 1", cnt_s, 160);
        chk("R9", "ticks with generator select", cnt_b, 10);

        // R2: prescaled source
        clk_sel = 1'b1;
        run(16); zero(); run(512);
        chk("R2", "samples from divided clock", cnt_s, 64);
        chk("R2", "ticks from divided clock", cnt_b, 4);
        clk_sel = 1'b0;

        // R3: divisor 3
        wr(1'b0, 16'd3);
        run(20); zero(); run(96);
        chk("R3", "samples with divisor 3", cnt_s, 32);
        chk("R3", "ticks with divisor 3", cnt_b, 2);

        // R8: generator reload waits for the running period
        gap_to_next(1'b0, g);
        wr(1'b0, 16'd5);
        gap_to_next(1'b0, g);
        chk("R8", "gap finishing old generator period", g, 2);
        gap_to_next(1'b0, g);
        chk("R8", "gap with new generator divisor", g, 5);

        // R5: divisor 0 stops everything
        wr(1'b0, 16'd0);
        run(20); zero(); run(500);
        chk("R5", "samples when stopped", cnt_s, 0);
        chk("R5", "ticks when stopped", cnt_b, 0);

        // R7: low bit-divisor writes dropped
        wr(1'b0, 16'd1);
        run(20);
        wr(1'b1, 16'd2);
        wr(1'b1, 16'h0103);
        run(40); zero(); run(160);
        chk("R7", "ticks after dropped writes (period 16)", cnt_b, 10);
        wr(1'b1, 16'd4);
        run(40); zero(); run(50);
        chk("R6", "ticks with bit divisor 4", cnt_b, 10);
        wr(1'b1, 16'd3);
        run(20); zero(); run(50);
        chk("R7", "ticks after write of 3", cnt_b, 10);

        // R8: bit divisor reload waits for next tick
        gap_to_next(1'b1, g);
        wr(1'b1, 16'd9);
        gap_to_next(1'b1, g);
        chk("R8", "gap finishing old bit period", g, 4);
        gap_to_next(1'b1, g);
        chk("R8", "gap with new bit divisor", g, 10);

        // R6: top of range
        wr(1'b1, 16'd255);
        run(300); zero(); run(512);
        chk("R6", "ticks with bit divisor 255", cnt_b, 2);

        // R7: upper bits ignored, low byte 4 accepted
        wr(1'b1, 16'h1F04);
        run(300); zero(); run(50);
        chk("R7", "ticks with low byte 4", cnt_b, 10);

        // writes landing on terminal cycles, judged by the cycle model (R8)
        for (int i = 0; i < 24; i++) begin
            wr(1'b0, 16'(2 + (i % 3)));
            run(i % 4);
        end
        run(40);

        finish_run();
    end
endmodule